// File: doc/BRIEF.md
# Register-to-I2C Bridge

This block lets on-chip control logic read and write the configuration registers of an attached serial peripheral, such as an image sensor, as if they were plain memory locations. The caller supplies a register index, a write byte and a direction, then pulses `go`. The bridge then runs the whole two-wire bus transaction on its own. It drives the serial clock and pulls the serial data line low or releases it, without ever driving it high. When the bus has returned to idle, it reports completion with a one-cycle `done`.

The peripheral is addressed through two separate 8-bit device addresses: one for write phases and one for read phases. Both are set by parameters. The serial clock rate is derived from the system clock frequency, with 100 kHz as the default. Each bit period is split into four equal quarters.

If the peripheral fails to acknowledge any byte, the transaction is cut short with a STOP condition. `err` is then raised in the same cycle as `done`.

Top module: `regbus_i2c_bridge`

## Requirements
- R1: After reset, and in every cycle where `busy` is low, `scl` is 1 and `sda_low` is 0. After reset, `busy`, `done` and `err` are 0.
- R2: A `go` pulse is accepted only when `busy` is low and exactly one of `wr_req`/`rd_req` is 1. `busy` then reads 1 in the following cycle. A `go` pulse with both or neither request set leaves `busy` low.
- R3: A write sends, MSB first, a START, the write device address (default 0x42), the register index, the data byte and a STOP. That makes exactly one START and one STOP. A byte counts as acknowledged when the peripheral holds SDA low on the ninth clock.
- R4: A read sends a START, the write device address, the register index, a repeated START and the read device address (default 0x43). It then clocks in one byte MSB first, answers with a NACK (SDA released) and sends a STOP. That makes two STARTs and one STOP. `rd_data` holds the received byte from `done` onwards.
- R5: Consecutive rising edges of `scl` within a transaction are CLK_HZ/SCL_HZ system clocks apart.
- R6: A missing acknowledge on any sent byte ends the transaction with a STOP, and the remaining bytes are not sent. A rejected write leaves the peripheral register unchanged. A rejected read address byte produces no repeated START.
- R7: `err` is updated only in the `done` cycle. It is 1 after an aborted transaction and 0 after a completed one, and it holds that value until the next accepted request.
- R8: `busy` stays high until the STOP condition has completed. `done` is a single-cycle pulse in the first cycle in which `busy` is low again.
- R9: `go` while `busy` is high is ignored. The running transaction keeps the index, data and direction it latched when it was accepted.
- R10: While `scl` stays high, `sda_low` changes only to form a START (it rises) or a STOP (it falls).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go | input | 1 | Start command; launches the selected request |
| wr_req | input | 1 | Selects a register write |
| rd_req | input | 1 | Selects a register read |
| reg_addr | input | 8 | Peripheral register index |
| wr_data | input | 8 | Byte to write |
| rd_data | output | 8 | Byte returned by the last read |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last transaction was not acknowledged |
| scl | output | 1 | Serial clock |
| sda_low | output | 1 | 1 pulls the serial data line low, 0 releases it |
| sda_in | input | 1 | Sensed level of the serial data line |

## Verification
The interesting collision is a new `go` arriving in the very cycle in which the previous transaction completes. In that cycle `done` pulses and `busy` drops, so an acceptance and a completion share one clock. The bench provokes this by starting a write and then holding `go` high with a read request for the same register throughout the write. Every sample taken while `busy` is high must be ignored. The hold must be accepted in the `done` cycle, giving `busy` low for exactly one sample. The read must then return the byte the write just stored, with `err` low.

// File: rtl/i2cb_pkg.sv
// Shared types for the register-to-I2C bridge.
// Assumes byte-wide bus transfers; all encodings are internal to the block.
package i2cb_pkg;
    localparam int BYTE_W = 8;

    // Bus primitives executed by the bit engine, each lasting four quarters
    typedef enum logic [1:0] {
        BIT_START = 2'd0,
        BIT_STOP  = 2'd1,
        BIT_WRITE = 2'd2,
        BIT_READ  = 2'd3
    } bit_op_e;

    typedef struct packed {
        bit_op_e op;
        logic    wbit;
    } bit_cmd_t;

    // Transaction sequencer phases
    typedef enum logic [2:0] {
        SQ_IDLE    = 3'd0,
        SQ_START   = 3'd1,
        SQ_TX      = 3'd2,
        SQ_RESTART = 3'd3,
        SQ_RX      = 3'd4,
        SQ_STOP    = 3'd5
    } seq_state_e;
endpackage

// File: rtl/i2cb_qtick.sv
// Quarter-bit tick generator.
// Emits a one-cycle pulse every QTR_CYCLES clocks; assumes QTR_CYCLES >= 2.
module i2cb_qtick #(
    parameter int QTR_CYCLES = 250
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (QTR_CYCLES > 1) ? $clog2(QTR_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(QTR_CYCLES - 1);

    logic [CW-1:0] cnt;

    assign tick = (cnt == LAST);

    // Free-running modulo counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/i2cb_bitphy.sv
// Bit engine: runs one bus primitive (START, STOP, write bit, read bit)
// over four quarter ticks and drives SCL and the SDA pull-down.
// Assumes a new command is only offered while the engine is idle.
// Each primitive ends with SCL low, except STOP, which leaves the bus idle.
module i2cb_bitphy
    import i2cb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  logic     cmd_valid,
    input  bit_cmd_t cmd,
    input  logic     sda_in,
    output logic     cmd_done,
    output logic     rbit,
    output logic     scl,
    output logic     sda_low,
    output bit_op_e  cur_op
);
    logic     active;
    logic [1:0] qtr;
    bit_cmd_t cmd_r;
    logic [1:0] sda_sync;

    assign cmd_done = active && tick && (qtr == 2'd3);
    assign cur_op   = cmd_r.op;

    // Bring the sensed data line into the clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sda_sync <= 2'b11;
        end else begin
            sda_sync <= {sda_sync[0], sda_in};
        end
    end

    // Primitive execution, one bus action per quarter tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            qtr     <= 2'd0;
            cmd_r   <= '0;
            scl     <= 1'b1;
            sda_low <= 1'b0;
            rbit    <= 1'b1;
        end else if (!active) begin
            if (cmd_valid) begin
                active <= 1'b1;
                qtr    <= 2'd0;
                cmd_r  <= cmd;
            end
        end else if (tick) begin
            qtr <= qtr + 2'd1;
            if (qtr == 2'd3) begin
                active <= 1'b0;
            end
            case (cmd_r.op)
                BIT_START: begin
                    case (qtr)
                        2'd0: begin scl <= 1'b0; sda_low <= 1'b0; end
                        2'd1: scl <= 1'b1;
                        2'd2: sda_low <= 1'b1;
                        default: scl <= 1'b0;
                    endcase
                end
                BIT_STOP: begin
                    case (qtr)
                        2'd0: begin scl <= 1'b0; sda_low <= 1'b1; end
                        2'd1: scl <= 1'b1;
                        2'd2: sda_low <= 1'b0;
                        default: ;
                    endcase
                end
                BIT_WRITE: begin
                    case (qtr)
                        2'd0: begin scl <= 1'b0; sda_low <= !cmd_r.wbit; end
                        2'd1: scl <= 1'b1;
                        2'd2: ;
                        default: scl <= 1'b0;
                    endcase
                end
                BIT_READ: begin
                    case (qtr)
                        2'd0: begin scl <= 1'b0; sda_low <= 1'b0; end
                        2'd1: scl <= 1'b1;
                        2'd2: rbit <= sda_sync[1];
                        default: scl <= 1'b0;
                    endcase
                end
            endcase
        end
    end
endmodule

// File: rtl/i2cb_txnseq.sv
// Transaction sequencer: turns one register request into the ordered
// list of bus primitives, checks each acknowledge and reports the outcome.
// Assumes the bit engine accepts a command in the cycle cmd_valid is high
// and signals completion with bit_done.
module i2cb_txnseq
    import i2cb_pkg::*;
#(
    parameter logic [7:0] DEV_WADDR = 8'h42,
    parameter logic [7:0] DEV_RADDR = 8'h43
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              wr_req,
    input  logic              rd_req,
    input  logic [BYTE_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              bit_done,
    input  logic              rbit,
    output logic              cmd_valid,
    output bit_cmd_t          cmd,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [BYTE_W-1:0] rd_data
);
    seq_state_e        state;
    logic              is_read;
    logic [BYTE_W-1:0] addr_r;
    logic [BYTE_W-1:0] data_r;
    logic [3:0]        bitcnt;
    logic [1:0]        byte_idx;
    logic [BYTE_W-1:0] rx_sh;
    logic              waiting;
    logic              nack_r;
    logic [BYTE_W-1:0] cur_byte;
    logic              accept;
    logic              in_byte;

    assign accept    = go && (state == SQ_IDLE) && (rd_req ^ wr_req);
    assign busy      = (state != SQ_IDLE);
    assign cmd_valid = busy && !waiting;
    assign in_byte   = (bitcnt < 4'd8);

    // Byte currently being sent, chosen by its place in the transaction
    always_comb begin
        case (byte_idx)
            2'd0:    cur_byte = DEV_WADDR;
            2'd1:    cur_byte = addr_r;
            default: cur_byte = is_read ? DEV_RADDR : data_r;
        endcase
    end

    // Primitive requested from the bit engine in each phase
    always_comb begin
        cmd = '{op: BIT_STOP, wbit: 1'b1};
        case (state)
            SQ_START, SQ_RESTART: cmd.op = BIT_START;
            SQ_TX: begin
                if (in_byte) begin
                    cmd.op   = BIT_WRITE;
                    cmd.wbit = cur_byte[3'd7 - bitcnt[2:0]];
                end else begin
                    cmd.op = BIT_READ;
                end
            end
            SQ_RX: begin
                cmd.op   = in_byte ? BIT_READ : BIT_WRITE;
                cmd.wbit = 1'b1;
            end
            default: cmd.op = BIT_STOP;
        endcase
    end

    // Request capture and phase stepping on each finished primitive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SQ_IDLE;
            is_read  <= 1'b0;
            addr_r   <= '0;
            data_r   <= '0;
            bitcnt   <= '0;
            byte_idx <= '0;
            rx_sh    <= '0;
            waiting  <= 1'b0;
            nack_r   <= 1'b0;
            done     <= 1'b0;
            err      <= 1'b0;
            rd_data  <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                state    <= SQ_START;
                is_read  <= rd_req;
                addr_r   <= reg_addr;
                data_r   <= wr_data;
                bitcnt   <= '0;
                byte_idx <= '0;
                waiting  <= 1'b0;
                nack_r   <= 1'b0;
                err      <= 1'b0;
            end else if (busy) begin
                if (cmd_valid) begin
                    waiting <= 1'b1;
                end
                if (bit_done) begin
                    waiting <= 1'b0;
                    case (state)
                        SQ_START: begin
                            state  <= SQ_TX;
                            bitcnt <= '0;
                        end
                        SQ_RESTART: begin
                            state    <= SQ_TX;
                            bitcnt   <= '0;
                            byte_idx <= 2'd2;
                        end
                        SQ_TX: begin
                            if (in_byte) begin
                                bitcnt <= bitcnt + 4'd1;
                            end else if (rbit) begin
                                nack_r <= 1'b1;
                                state  <= SQ_STOP;
                            end else if (byte_idx == 2'd2) begin
                                bitcnt <= '0;
                                state  <= is_read ? SQ_RX : SQ_STOP;
                            end else if (byte_idx == 2'd1 && is_read) begin
                                state <= SQ_RESTART;
                            end else begin
                                byte_idx <= byte_idx + 2'd1;
                                bitcnt   <= '0;
                            end
                        end
                        SQ_RX: begin
                            if (in_byte) begin
                                rx_sh  <= {rx_sh[BYTE_W-2:0], rbit};
                                bitcnt <= bitcnt + 4'd1;
                            end else begin
                                rd_data <= rx_sh;
                                state   <= SQ_STOP;
                            end
                        end
                        SQ_STOP: begin
                            state <= SQ_IDLE;
                            done  <= 1'b1;
                            err   <= nack_r;
                        end
                        default: state <= SQ_IDLE;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/regbus_i2c_bridge.sv
// Top level: memory-style register request port in front of a
// single-master two-wire bus. SCL is driven push-pull; SDA is only pulled
// low or released. Assumes CLK_HZ >= 8 * SCL_HZ.
module regbus_i2c_bridge
    import i2cb_pkg::*;
#(
    parameter int         CLK_HZ    = 100_000_000,
    parameter int         SCL_HZ    = 100_000,
    parameter logic [7:0] DEV_WADDR = 8'h42,
    parameter logic [7:0] DEV_RADDR = 8'h43
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              wr_req,
    input  logic              rd_req,
    input  logic [BYTE_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              scl,
    output logic              sda_low,
    input  logic              sda_in
);
    localparam int QTR_CYCLES = CLK_HZ / (4 * SCL_HZ);

    logic     tick;
    logic     cmd_valid;
    bit_cmd_t cmd;
    logic     bit_done;
    logic     rbit;
    bit_op_e  phy_op;

    i2cb_qtick #(.QTR_CYCLES(QTR_CYCLES)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    i2cb_bitphy u_phy (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .sda_in    (sda_in),
        .cmd_done  (bit_done),
        .rbit      (rbit),
        .scl       (scl),
        .sda_low   (sda_low),
        .cur_op    (phy_op)
    );

    i2cb_txnseq #(.DEV_WADDR(DEV_WADDR), .DEV_RADDR(DEV_RADDR)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .wr_req    (wr_req),
        .rd_req    (rd_req),
        .reg_addr  (reg_addr),
        .wr_data   (wr_data),
        .bit_done  (bit_done),
        .rbit      (rbit),
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .busy      (busy),
        .done      (done),
        .err       (err),
        .rd_data   (rd_data)
    );
endmodule

// File: rtl/regbus_i2c_bridge_chk.sv
// Protocol checker for regbus_i2c_bridge, attached by bind.
// Observes the request port, the bus pins and the bit engine's primitive.
module regbus_i2c_bridge_chk
    import i2cb_pkg::*;
(
    input logic    clk,
    input logic    rst_n,
    input logic    go,
    input logic    wr_req,
    input logic    rd_req,
    input logic    busy,
    input logic    done,
    input logic    err,
    input logic    scl,
    input logic    sda_low,
    input bit_op_e phy_op
);
    // R1: bus idles whenever no transaction runs
    p_idle_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (scl && !sda_low));

    // R2: a valid start command while idle is taken
    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !busy && (rd_req ^ wr_req)) |=> busy);

    // R2: nothing else starts a transaction
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(go && (rd_req ^ wr_req))) |=> !busy);

    // R8: completion pulse marks the end of busy
    p_done_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R8: completion is a single-cycle pulse
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: error flag rises only together with completion
    p_err_at_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> done);

    // R10: data moves under a high clock only for START or STOP
    p_sda_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (scl && $past(scl) && (sda_low != $past(sda_low))) |->
        ((phy_op == BIT_START && sda_low) || (phy_op == BIT_STOP && !sda_low)));
endmodule

bind regbus_i2c_bridge regbus_i2c_bridge_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (go),
    .wr_req  (wr_req),
    .rd_req  (rd_req),
    .busy    (busy),
    .done    (done),
    .err     (err),
    .scl     (scl),
    .sda_low (sda_low),
    .phy_op  (phy_op)
);

// File: tb/tb_regbus_i2c_bridge.sv
// Bench: a behavioural peripheral on the bus, a vector table of register
// writes and reads, then directed tests for reset, rejection and aborts.
module tb_regbus_i2c_bridge;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       go = 1'b0, wr_req = 1'b0, rd_req = 1'b0;
    logic [7:0] reg_addr = '0, wr_data = '0;
    logic [7:0] rd_data;
    logic       busy, done, err, scl, sda_low;
    logic       sda_line;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    // Peripheral model state
    typedef enum logic [2:0] {P_IDLE, P_RX, P_ACK, P_TX, P_TXACK} pst_e;
    pst_e       pst;
    logic       p_scl = 1'b1, p_sda = 1'b1;
    logic       slv_low;
    logic [3:0] bitc;
    logic [1:0] byte_no;
    logic [7:0] shreg, tx_sh;
    logic [3:0] reg_ptr;
    logic       rdm;
    logic [7:0] smem [0:15];
    int         n_start = 0, n_stop = 0;
    logic       nack_addr = 1'b0, nack_data = 1'b0;

    assign sda_line = !(sda_low || slv_low);

    regbus_i2c_bridge #(.CLK_HZ(4_000_000), .SCL_HZ(100_000)) dut (
        .clk(clk), .rst_n(rst_n), .go(go), .wr_req(wr_req), .rd_req(rd_req),
        .reg_addr(reg_addr), .wr_data(wr_data), .rd_data(rd_data),
        .busy(busy), .done(done), .err(err), .scl(scl), .sda_low(sda_low),
        .sda_in(sda_line)
    );

    // Peripheral: answers 0x42 (write) and 0x43 (read), 16 registers
    always @(posedge clk) begin
        p_scl <= scl;
        p_sda <= sda_line;
        if (!rst_n) begin
            pst <= P_IDLE; slv_low <= 1'b0; bitc <= '0; byte_no <= '0;
            shreg <= '0; tx_sh <= '0; reg_ptr <= '0; rdm <= 1'b0;
            for (int i = 0; i < 16; i++) smem[i] <= 8'h10 + 8'(i);
        end else if (p_scl && scl && p_sda && !sda_line) begin
            n_start <= n_start + 1; pst <= P_RX; bitc <= '0; byte_no <= '0; slv_low <= 1'b0;
        end else if (p_scl && scl && !p_sda && sda_line) begin
            n_stop <= n_stop + 1; pst <= P_IDLE; slv_low <= 1'b0;
        end else if (!p_scl && scl) begin
            if (pst == P_RX) begin
                shreg <= {shreg[6:0], sda_line};
                bitc  <= bitc + 4'd1;
            end
        end else if (p_scl && !scl) begin
            case (pst)
                P_RX: if (bitc == 4'd8) begin
                    logic ok;
                    ok = 1'b1;
                    if (byte_no == 2'd0) begin
                        ok  = (shreg == 8'h42 || shreg == 8'h43) && !nack_addr;
                        rdm <= shreg[0];
                    end else if (byte_no == 2'd1) begin
                        reg_ptr <= shreg[3:0];
                    end else begin
                        ok = !nack_data;
                        if (ok) smem[reg_ptr] <= shreg;
                    end
                    slv_low <= ok;
                    pst     <= ok ? P_ACK : P_IDLE;
                end
                P_ACK: begin
                    if (rdm) begin
                        tx_sh   <= smem[reg_ptr];
                        slv_low <= !smem[reg_ptr][7];
                        bitc    <= '0;
                        pst     <= P_TX;
                    end else begin
                        slv_low <= 1'b0;
                        bitc    <= '0;
                        byte_no <= byte_no + 2'd1;
                        pst     <= P_RX;
                    end
                end
                P_TX: begin
                    if (bitc == 4'd7) begin
                        slv_low <= 1'b0;
                        pst     <= P_TXACK;
                    end else begin
                        slv_low <= !tx_sh[6];
                        tx_sh   <= {tx_sh[6:0], 1'b0};
                        bitc    <= bitc + 4'd1;
                    end
                end
                P_TXACK: begin slv_low <= 1'b0; pst <= P_IDLE; end
                default: slv_low <= 1'b0;
            endcase
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Waits for done at a negedge; returns busy seen one sample earlier
    task automatic wait_done(output logic prev_busy);
        int n;
        logic pb;
        n = 0;
        pb = busy;
        while (!done && n < 20000) begin
            pb = busy;
            @(negedge clk);
            n++;
        end
        prev_busy = pb;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R8 done timeout actual 0 expected 1");
        end
    endtask

    task automatic launch(input logic rd, input logic [7:0] ra, input logic [7:0] wd);
        @(negedge clk);
        go = 1'b1; rd_req = rd; wr_req = !rd; reg_addr = ra; wr_data = wd;
        @(negedge clk);
        go = 1'b0; rd_req = 1'b0; wr_req = 1'b0;
    endtask

    // {read, register, write data, expected read data}
    localparam logic [24:0] VEC [0:7] = '{
        {1'b0, 8'h03, 8'hA5, 8'h00},
        {1'b1, 8'h03, 8'h00, 8'hA5},
        {1'b0, 8'h07, 8'h3C, 8'h00},
        {1'b1, 8'h07, 8'h00, 8'h3C},
        {1'b1, 8'h03, 8'h00, 8'hA5},
        {1'b0, 8'h00, 8'h00, 8'h00},
        {1'b0, 8'h0F, 8'hFF, 8'h00},
        {1'b1, 8'h0F, 8'h00, 8'hFF}
    };

    initial begin
        #(4 * 190000);
        errors++;
        checks++;
        $display("FAIL watchdog actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic pb;
        int s0, t0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 err", err, 0);
        chk("R1 scl", scl, 1); chk("R1 sda", sda_low, 0);

        // Vector table: R3 writes, R4 reads, R10 start/stop counts
        for (int v = 0; v < 8; v++) begin
            logic rd;
            logic [7:0] ra, wd, ex;
            {rd, ra, wd, ex} = VEC[v];
            s0 = n_start; t0 = n_stop;
            launch(rd, ra, wd);
            chk("R2 busy after go", busy, 1);
            wait_done(pb);
            chk("R8 busy before done", pb, 1);
            chk("R8 busy low at done", busy, 0);
            chk("R7 err clear", err, 0);
            @(negedge clk);
            chk("R8 done single", done, 0);
            chk("R1 idle scl", scl, 1);
            chk("R10 stop count", n_stop - t0, 1);
            if (rd) begin
                chk("R4 rd_data", rd_data, ex);
                chk("R4 two starts", n_start - s0, 2);
            end else begin
                chk("R3 reg written", smem[ra[3:0]], wd);
                chk("R3 one start", n_start - s0, 1);
            end
        end

        // R2: invalid request combinations are rejected
        @(negedge clk);
        go = 1'b1; rd_req = 1'b1; wr_req = 1'b1;
        @(negedge clk);
        chk("R2 both set rejected", busy, 0);
        rd_req = 1'b0; wr_req = 1'b0;
        @(negedge clk);
        chk("R2 none set rejected", busy, 0);
        go = 1'b0;

        // R5 clock period and R9 go-while-busy ignored
        launch(1'b0, 8'h04, 8'h66);
        begin
            int t, r1, r2;
            logic ps;
            t = 0; r1 = -1; r2 = -1; ps = scl;
            while (r2 < 0 && t < 2000) begin
                @(negedge clk);
                t++;
                if (scl && !ps) begin
                    if (r1 < 0) r1 = t; else r2 = t;
                end
                ps = scl;
            end
            chk("R5 scl period", r2 - r1, 40);
        end
        go = 1'b1; wr_req = 1'b1; reg_addr = 8'h04; wr_data = 8'h99;
        @(negedge clk);
        go = 1'b0; wr_req = 1'b0;
        wait_done(pb);
        repeat (20) @(negedge clk);
        chk("R9 late go ignored, data kept", smem[4], 8'h66);
        chk("R9 no second transaction", busy, 0);

        // R6/R7: data byte not acknowledged on a write
        nack_data = 1'b1;
        s0 = n_start; t0 = n_stop;
        launch(1'b0, 8'h05, 8'h77);
        wait_done(pb);
        chk("R7 err with done", err, 1);
        chk("R6 register unchanged", smem[5], 8'h15);
        chk("R6 stop sent", n_stop - t0, 1);
        repeat (30) @(negedge clk);
        chk("R7 err held", err, 1);
        nack_data = 1'b0;

        // R6: address not acknowledged on a read, no repeated START
        nack_addr = 1'b1;
        s0 = n_start;
        launch(1'b1, 8'h02, 8'h00);
        wait_done(pb);
        chk("R6 addr nack err", err, 1);
        chk("R6 no restart", n_start - s0, 1);
        chk("R6 rd_data kept", rd_data, 8'hFF);
        nack_addr = 1'b0;

        // R7: successful transaction clears err
        launch(1'b1, 8'h06, 8'h00);
        wait_done(pb);
        chk("R7 err cleared", err, 0);
        chk("R4 reset value read", rd_data, 8'h16);

        // R8/R2: go held through a write, accepted in the done cycle
        @(negedge clk);
        go = 1'b1; wr_req = 1'b1; reg_addr = 8'h09; wr_data = 8'h5A;
        @(negedge clk);
        wr_req = 1'b0; rd_req = 1'b1;
        wait_done(pb);
        chk("R8 done with busy low", busy, 0);
        @(negedge clk);
        go = 1'b0; rd_req = 1'b0;
        chk("R2 accepted in done cycle", busy, 1);
        wait_done(pb);
        chk("R9 write kept its data", smem[9], 8'h5A);
        chk("R4 read after collision", rd_data, 8'h5A);
        chk("R7 collision err", err, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule